// File: doc/BRIEF.md
# Bit-Serial Distributed-Arithmetic FIR Filter

This block is a fixed-coefficient FIR filter that forms its inner product with no multiplier. Each accepted two's-complement sample is pushed into a delay line of T taps. The filter then takes one bit weight per clock, starting with the least significant bit. For each weight it collects that bit from every tap into a T-bit address. It reads a table that holds every possible sum of the coefficients. It folds the entry it reads into a scaling accumulator that shifts right by one bit each step. The step for the sign bit subtracts its entry, because that bit carries negative weight.

The coefficients are compile-time parameters. The table contents are computed during elaboration, with 2^T entries. A result takes N clock steps, one for each sample bit. While a result is being computed, the block shows that it is busy and takes no new sample. A new sample can be offered in the same cycle that the previous result is flagged valid.

Top module: `dafir_top`

## Requirements
- R1: While reset is held and in the cycle after it, in_ready is 1, out_valid is 0 and out_result is 0. Reset also clears every tap of the delay line to zero.
- R2: When out_valid is 1, out_result equals sum over i of c_i * x_i, computed at full precision as a signed number. c_i is the coefficient held in bits [i*CW +: CW] of COEFS. x_0 is the newest accepted sample and x_i is the one accepted i transfers earlier, taken as 0 if it does not exist.
- R3: A sample is accepted on a rising edge where in_valid and in_ready are both 1. out_valid is then 1 for exactly one cycle, starting N rising edges after the accepting edge.
- R4: in_ready is 0 from the edge after an accept until out_valid rises. in_ready is 1 in the out_valid cycle and whenever no result is pending.
- R5: in_valid asserted while in_ready is 0 has no effect. That sample never appears in any later result.
- R6: Samples are two's complement, and the most significant bit carries weight -2^(N-1). The most negative and the most positive samples give exact products with the extreme coefficients.
- R7: A table entry for address a is the sum of c_t over the taps whose bit t is 1 in a. Therefore a single sample of value 1 followed by zeros gives the results c_0, c_1, …, c_(T-1), then 0.
- R8: A sample offered in the out_valid cycle is accepted on the next edge. Its result follows after N more edges, with no idle cycle between the two results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Sample offered |
| in_sample | input | N | Two's-complement input sample |
| in_ready | output | 1 | Block idle; an offered sample is taken on this edge |
| out_valid | output | 1 | One-cycle strobe marking out_result valid |
| out_result | output | N+CW+clog2(T)+1 | Signed full-precision filter output |

## Verification
The bench tries the filter with several kinds of input:
- An impulse of value 1 followed by zeros. The outputs read back the coefficients one at a time. This exposes a wrong table entry or reversed tap order.
- Runs of the most negative and most positive samples. These separate a sign step that adds from one that subtracts, and catch an accumulator that is too narrow.
- A seeded random stream that mixes back-to-back transfers, idle gaps and samples offered while busy. This tells correct shift weighting from wrong weighting. It also checks that busy-time samples leave the delay line untouched.

// File: rtl/dafir_pkg.sv
package dafir_pkg;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } dafir_state_e;

    // control word handed from the sequencer to the datapath
    typedef struct packed {
        logic load;   // a sample is taken this cycle
        logic step;   // a bit-weight step is performed
        logic sign;   // this step handles the sign bit
    } dafir_ctl_t;

    function automatic int idx_bits(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

    function automatic int sum_bits(input int cw, input int taps);
        return cw + ((taps > 1) ? $clog2(taps) : 0);
    endfunction

endpackage

// File: rtl/dafir_taps.sv
module dafir_taps #(
    parameter int T  = 4,
    parameter int N  = 8,
    parameter int BW = 3
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           shift_en,
    input  logic [N-1:0]   din,
    input  logic [BW-1:0]  bit_sel,
    output logic [T-1:0]   addr,
    output logic [T*N-1:0] taps_flat
);
    logic [N-1:0] tap_q [T];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < T; i++) tap_q[i] <= '0;
        end else if (shift_en) begin
            tap_q[0] <= din;
            for (int i = 1; i < T; i++) tap_q[i] <= tap_q[i-1];
        end
    end

    for (genvar t = 0; t < T; t++) begin : g_tap
        assign addr[t]                = tap_q[t][bit_sel];
        assign taps_flat[t*N +: N]    = tap_q[t];
    end
endmodule

// File: rtl/dafir_table.sv
module dafir_table #(
    parameter int              T     = 4,
    parameter int              CW    = 8,
    parameter int              LW    = 10,
    parameter logic [T*CW-1:0] COEFS = '0
) (
    input  logic [T-1:0]          addr,
    output logic signed [LW-1:0]  value
);
    localparam int DEPTH = 1 << T;

    function automatic logic signed [LW-1:0] entry(input int a);
        logic signed [LW-1:0] acc;
        acc = '0;
        for (int t = 0; t < T; t++) begin
            if (a[t]) acc = acc + LW'($signed(COEFS[t*CW +: CW]));
        end
        return acc;
    endfunction

    logic signed [LW-1:0] tbl [DEPTH];

    for (genvar a = 0; a < DEPTH; a++) begin : g_ent
        assign tbl[a] = entry(a);
    end

    assign value = tbl[addr];
endmodule

// File: rtl/dafir_acc.sv
module dafir_acc #(
    parameter int N  = 8,
    parameter int LW = 10,
    parameter int W  = 19
) (
    input  logic                  clk,
    input  logic                  rst,
    input  dafir_pkg::dafir_ctl_t ctl,
    input  logic signed [LW-1:0]  part,
    output logic signed [W-1:0]   acc
);
    logic signed [W-1:0] term;
    logic signed [W-1:0] shifted;
    logic signed [W-1:0] nxt;

    always_comb begin
        term    = W'(part) <<< (N - 1);
        shifted = acc >>> 1;
        nxt     = ctl.sign ? (shifted - term) : (shifted + term);
    end

    always_ff @(posedge clk) begin
        if (rst || ctl.load) acc <= '0;
        else if (ctl.step)   acc <= nxt;
    end
endmodule

// File: rtl/dafir_seq.sv
module dafir_seq #(
    parameter int N  = 8,
    parameter int BW = 3
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  in_valid,
    output logic                  in_ready,
    output dafir_pkg::dafir_ctl_t ctl,
    output logic [BW-1:0]         bit_idx,
    output logic                  done
);
    import dafir_pkg::*;

    dafir_state_e state;
    logic [BW-1:0] cnt;
    logic          last;

    assign in_ready = (state == ST_IDLE);
    assign last     = (state == ST_RUN) && (cnt == BW'(N - 1));
    assign bit_idx  = cnt;

    always_comb begin
        ctl.load = in_ready && in_valid;
        ctl.step = (state == ST_RUN);
        ctl.sign = last;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            cnt   <= '0;
            done  <= 1'b0;
        end else begin
            done <= last;
            case (state)
                ST_IDLE: if (ctl.load) begin
                    state <= ST_RUN;
                    cnt   <= '0;
                end
                ST_RUN: begin
                    if (last) state <= ST_IDLE;
                    else      cnt   <= cnt + 1'b1;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/dafir_top.sv
module dafir_top #(
    parameter int              T     = 4,
    parameter int              N     = 8,
    parameter int              CW    = 8,
    parameter logic [T*CW-1:0] COEFS = {8'hF3, 8'h7F, 8'h80, 8'h25},
    localparam int             LW    = dafir_pkg::sum_bits(CW, T),
    localparam int             W     = N + LW + 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    input  logic [N-1:0] in_sample,
    output logic         in_ready,
    output logic         out_valid,
    output logic [W-1:0] out_result
);
    import dafir_pkg::*;

    localparam int BW = idx_bits(N);

    dafir_ctl_t            ctl;
    logic [BW-1:0]         bit_idx;
    logic [T-1:0]          addr;
    logic [T*N-1:0]        taps_flat;
    logic signed [LW-1:0]  part;
    logic signed [W-1:0]   acc;

    dafir_seq #(.N(N), .BW(BW)) u_seq (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .ctl(ctl), .bit_idx(bit_idx), .done(out_valid)
    );

    dafir_taps #(.T(T), .N(N), .BW(BW)) u_taps (
        .clk(clk), .rst(rst), .shift_en(ctl.load), .din(in_sample),
        .bit_sel(bit_idx), .addr(addr), .taps_flat(taps_flat)
    );

    dafir_table #(.T(T), .CW(CW), .LW(LW), .COEFS(COEFS)) u_tbl (
        .addr(addr), .value(part)
    );

    dafir_acc #(.N(N), .LW(LW), .W(W)) u_acc (
        .clk(clk), .rst(rst), .ctl(ctl), .part(part), .acc(acc)
    );

    assign out_result = acc;
endmodule

// File: rtl/dafir_chk.sv
module dafir_chk #(
    parameter int T = 4,
    parameter int N = 8
) (
    input logic           clk,
    input logic           rst,
    input logic           in_valid,
    input logic           in_ready,
    input logic           out_valid,
    input logic [T*N-1:0] taps
);
    int   since;
    logic armed;

    always_ff @(posedge clk) begin
        if (rst) begin
            since <= 0;
            armed <= 1'b0;
        end else if (in_valid && in_ready) begin
            since <= 0;
            armed <= 1'b1;
        end else if (since < N + 2) begin
            since <= since + 1;
        end
    end

    // R3
    strobe_single_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> !out_valid);

    // R3
    strobe_timing_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (armed && since == N));

    // R4
    busy_after_take_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> !in_ready);

    // R4
    busy_window_chk: assert property (@(posedge clk) disable iff (rst)
        !in_ready |-> (armed && since < N));

    // R4
    ready_at_done_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> in_ready);

    // R5
    busy_ignore_chk: assert property (@(posedge clk) disable iff (rst)
        !in_ready |=> $stable(taps));
endmodule

bind dafir_top dafir_chk #(.T(T), .N(N)) u_chk (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .out_valid(out_valid), .taps(taps_flat)
);

// File: tb/sim_dafir_top.sv
`timescale 1ns/1ps
module sim_dafir_top;
    localparam int              T     = 4;
    localparam int              N     = 8;
    localparam int              CW    = 8;
    localparam logic [T*CW-1:0] COEFS = {8'hF3, 8'h7F, 8'h80, 8'h25};
    localparam int              W     = N + CW + $clog2(T) + 1;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic [N-1:0] in_sample = '0;
    logic         in_ready;
    logic         out_valid;
    logic [W-1:0] out_result;

    int  checks = 0;
    int  errors = 0;
    bit  finished = 0;
    longint hist [T];

    always #4 clk = ~clk;

    dafir_top #(.T(T), .N(N), .CW(CW), .COEFS(COEFS)) u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_sample(in_sample),
        .in_ready(in_ready), .out_valid(out_valid), .out_result(out_result)
    );

    function automatic longint coef(input int i);
        return longint'($signed(COEFS[i*CW +: CW]));
    endfunction

    function automatic longint expect_out();
        longint s = 0;
        for (int i = 0; i < T; i++) s += coef(i) * hist[i];
        return s;
    endfunction

    task automatic check(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // drive at a negedge with in_ready high; returns at the negedge of out_valid
    task automatic push(input logic [N-1:0] x, input bit inject, input string req);
        check("R4", in_ready, 1);
        in_valid  = 1'b1;
        in_sample = x;
        for (int i = T - 1; i > 0; i--) hist[i] = hist[i-1];
        hist[0] = longint'($signed(x));
        for (int k = 1; k <= N + 1; k++) begin
            @(negedge clk);
            in_valid = 1'b0;
            if (inject && (k == 3 || k == 4)) begin
                in_valid  = 1'b1;          // R5: offered while busy
                in_sample = N'($urandom);
            end
            if (k <= N) begin
                check("R3", out_valid, 0);
                check("R4", in_ready, 0);
            end
        end
        in_valid = 1'b0;
        check("R3", out_valid, 1);
        check(req, longint'($signed(out_result)), expect_out());
    endtask

    task automatic gap(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            check("R3", out_valid, 0);
        end
    endtask

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < T; i++) hist[i] = 0;
        repeat (3) @(negedge clk);
        check("R1", in_ready, 1);
        check("R1", out_valid, 0);
        check("R1", out_result, 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1", in_ready, 1);
        check("R1", out_valid, 0);
        check("R1", out_result, 0);

        // R7: impulse reads back the coefficients
        push(N'(1), 0, "R7");
        for (int i = 0; i < T; i++) push('0, 0, "R7");

        // R6: extreme samples
        for (int i = 0; i < T; i++) push({1'b1, {(N-1){1'b0}}}, 0, "R6");
        for (int i = 0; i < T; i++) push({1'b0, {(N-1){1'b1}}}, 0, "R6");
        push({N{1'b1}}, 0, "R6");
        gap(3);

        // R5: samples offered while busy
        for (int i = 0; i < 6; i++) push(N'($urandom), 1, "R5");

        // R8 back-to-back, R2 random with occasional gaps
        for (int i = 0; i < 60; i++) begin
            push(N'($urandom), ($urandom % 4) == 0, (i % 2) ? "R2" : "R8");
            if (($urandom % 3) == 0) gap(1 + ($urandom % 3));
        end

        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule